// File: doc/BRIEF.md
# Discriminator Input Conditioning Unit

This unit sits between a bank of discriminator input lines and the timing logic that time-stamps them. Each channel can have its level inverted and its pulses widened. Inversion is applied first, and stretching acts on the inverted level. With stretching enabled, every pulse that a clock edge catches high is held for a fixed number of clock edges after the last edge that saw it high. The rising edge still passes straight through without waiting for a clock edge. The falling edge is then set by the clock and no longer follows the input's own falling edge.

A monitor multiplexer copies one conditioned channel onto a pair of spare test outputs. Three configuration registers hold the invert mask, the stretch mask and the monitor selector. A single-cycle write strobe with an address and a data word loads them. At the default clock of 8 ns and a hold of two edges, a stretched pulse lasts at least about 16 ns.

Top module: `input_conditioner`

## Requirements
- R1: After reset the invert mask and stretch mask are zero and the monitor selector is 0, so each output equals its raw input and the test outputs carry channel 0.
- R2: A write with `cfg_we_i` high loads the register chosen by `cfg_addr_i`: 0 the invert mask, 1 the stretch mask, 2 the monitor selector (low SEL_W bits of the data). The new value acts from the clock edge that samples the strobe. A write to address 3 changes no output.
- R3: A channel whose invert bit is 1 outputs the complement of its raw input. Channels whose invert bit is 0 pass the raw level.
- R4: With its stretch bit 0, a channel's output follows the inverted input within the same cycle, on both edges.
- R5: With its stretch bit 1, a channel's output rises in the same cycle as its inverted input rises, with no clock delay.
- R6: With its stretch bit 1, a pulse seen high at one clock edge keeps the output high until the STRETCH_CYC-th edge after that edge. It then falls if the inverted input is low. The default STRETCH_CYC is 2.
- R7: With its stretch bit 1, a pulse lasting several cycles keeps the output high for its whole length. The output then stays high until the STRETCH_CYC-th edge after the last edge that saw the input high.
- R8: Both bits of `mon_o` equal the conditioned output of the channel named by the monitor selector.
- R9: A monitor selector of NUM_CH or more drives both bits of `mon_o` low.
- R10: Channels are independent. Each channel's invert and stretch bits and its input history affect only that channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register address: 0 invert, 1 stretch, 2 monitor |
| cfg_wdata_i | input | NUM_CH | Write data |
| raw_i | input | NUM_CH | Raw discriminator inputs |
| cond_o | output | NUM_CH | Conditioned outputs |
| mon_o | output | 2 | Two copies of the monitored channel |

## Verification
Invert, monitor routing and the unstretched path are combinational, so their results are due in the cycle the input changes. A configuration write takes effect at the edge that samples the strobe, so it shows up in the following cycle. A stretched pulse's hold ends exactly STRETCH_CYC edges after the last edge that sampled it high. The bench drives inputs just after the falling clock edge, steps a reference model at each rising edge, and compares every output one time unit after driving. This way each result is sampled in the cycle it is due, and in every cycle.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned CFG_ADDR_W = 2;
  localparam logic [CFG_ADDR_W-1:0] CFG_INV = 2'd0;
  localparam logic [CFG_ADDR_W-1:0] CFG_STR = 2'd1;
  localparam logic [CFG_ADDR_W-1:0] CFG_MON = 2'd2;
endpackage

// File: rtl/cond_cfg_regs.sv
module cond_cfg_regs
  import cond_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned SEL_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CFG_ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0]     wdata_i,
  output logic [NUM_CH-1:0]     inv_mask_o,
  output logic [NUM_CH-1:0]     str_mask_o,
  output logic [SEL_W-1:0]      mon_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_mask_o <= '0;
      str_mask_o <= '0;
      mon_sel_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        CFG_INV: inv_mask_o <= wdata_i;
        CFG_STR: str_mask_o <= wdata_i;
        CFG_MON: mon_sel_o  <= wdata_i[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  // R2
  inv_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CFG_INV) |=> inv_mask_o == $past(wdata_i));
  // R2
  str_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CFG_STR) |=> str_mask_o == $past(wdata_i));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(inv_mask_o) && $stable(str_mask_o) && $stable(mon_sel_o)));
endmodule

// File: rtl/cond_channel.sv
module cond_channel #(
  parameter int unsigned STRETCH_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic inv_en_i,
  input  logic str_en_i,
  output logic out_o
);
  localparam int unsigned CNT_W = $clog2(STRETCH_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYC);

  logic             lvl;
  logic [CNT_W-1:0] cnt_q;

  assign lvl = raw_i ^ inv_en_i;

  // hold counter runs on the inverted level; enable only gates the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (lvl)           cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign out_o = lvl | (str_en_i & (cnt_q != '0));

  // R6
  hold_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl && str_en_i) |=> (out_o || !str_en_i));
  // R6
  hold_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl && str_en_i) |=> ##1 (out_o || !str_en_i));
  // R4
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !str_en_i |-> (out_o == (raw_i ^ inv_en_i)));
endmodule

// File: rtl/cond_monitor.sv
module cond_monitor #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cond_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [1:0]        mon_o
);
  localparam int unsigned SPAN = 1 << SEL_W;

  logic [SPAN-1:0] padded;

  for (genvar i = 0; i < SPAN; i++) begin : g_pad
    if (i < NUM_CH) begin : g_live
      assign padded[i] = cond_i[i];
    end else begin : g_zero
      assign padded[i] = 1'b0;
    end
  end

  assign mon_o = {2{padded[sel_i]}};

  // R8
  mon_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_o[0] == mon_o[1]);
  // R9
  mon_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel_i) >= NUM_CH) |-> mon_o == 2'b00);
endmodule

// File: rtl/input_conditioner.sv
module input_conditioner
  import cond_pkg::*;
#(
  parameter int unsigned NUM_CH      = 12,
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned STRETCH_CYC = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [NUM_CH-1:0]     cfg_wdata_i,
  input  logic [NUM_CH-1:0]     raw_i,
  output logic [NUM_CH-1:0]     cond_o,
  output logic [1:0]            mon_o
);
  logic [NUM_CH-1:0] inv_mask;
  logic [NUM_CH-1:0] str_mask;
  logic [SEL_W-1:0]  mon_sel;

  cond_cfg_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .inv_mask_o (inv_mask),
    .str_mask_o (str_mask),
    .mon_sel_o  (mon_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cond_channel #(.STRETCH_CYC(STRETCH_CYC)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raw_i    (raw_i[c]),
      .inv_en_i (inv_mask[c]),
      .str_en_i (str_mask[c]),
      .out_o    (cond_o[c])
    );
  end

  cond_monitor #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (cond_o),
    .sel_i  (mon_sel),
    .mon_o  (mon_o)
  );
endmodule

// File: tb/input_conditioner_tb_top.sv
`timescale 1ns/1ps
module input_conditioner_tb_top;
  localparam int NUM_CH = 12;
  localparam int SEL_W  = 4;
  localparam int STR    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [1:0]        addr = '0;
  logic [NUM_CH-1:0] wdata = '0;
  logic [NUM_CH-1:0] raw = '0;
  logic [NUM_CH-1:0] cond;
  logic [1:0]        mon;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  logic [NUM_CH-1:0] m_inv = '0;
  logic [NUM_CH-1:0] m_str = '0;
  int                m_sel = 0;
  int                age [NUM_CH];
  logic [15:0]       lfsr = 16'hACE1;

  always #4 clk = ~clk;

  input_conditioner #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .STRETCH_CYC(STR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .raw_i(raw), .cond_o(cond), .mon_o(mon)
  );

  initial for (int c = 0; c < NUM_CH; c++) age[c] = STR;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) age[c] = STR;
      m_inv = '0; m_str = '0; m_sel = 0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (raw[c] ^ m_inv[c]) age[c] = 0;
        else if (age[c] < STR) age[c] = age[c] + 1;
      end
      if (we) begin
        case (addr)
          2'd0: m_inv = wdata;
          2'd1: m_str = wdata;
          2'd2: m_sel = int'(wdata[SEL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [NUM_CH-1:0] exp_cond();
    logic [NUM_CH-1:0] e;
    for (int c = 0; c < NUM_CH; c++)
      e[c] = (raw[c] ^ m_inv[c]) | (m_str[c] && age[c] < STR);
    return e;
  endfunction

  task automatic compare(input string tag);
    logic [NUM_CH-1:0] ec;
    logic [1:0] em;
    ec = exp_cond();
    em = (m_sel < NUM_CH) ? {2{ec[m_sel]}} : 2'b00;
    total++;
    if (cond !== ec) begin
      bad++;
      $display("FAIL %s cond_o actual=%h expected=%h", tag, cond, ec);
    end
    total++;
    if (mon !== em) begin
      bad++;
      $display("FAIL %s mon_o actual=%b expected=%b", tag, mon, em);
    end
  endtask

  task automatic tick(input logic [NUM_CH-1:0] r, input string tag);
    @(negedge clk);
    we = 1'b0;
    raw = r;
    #1 compare(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [NUM_CH-1:0] d,
                    input logic [NUM_CH-1:0] r, input string tag);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; raw = r;
    #1 compare(tag);
  endtask

  function automatic logic [NUM_CH-1:0] next_pat();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[NUM_CH-1:0];
  endfunction

  initial begin
    // R1: reset values, during and right after reset
    tick(12'h3C5, "R1");
    tick(12'h0F0, "R1");
    @(negedge clk) rst_n = 1'b1;
    tick(12'h001, "R1");
    tick(12'h000, "R1");
    // R4: unstretched path follows input both ways
    for (int i = 0; i < 20; i++) tick(next_pat(), "R4");
    // R2 and R3: invert mask load and effect
    wr(2'd0, 12'hA5A, 12'h000, "R2");
    for (int i = 0; i < 10; i++) tick(next_pat(), "R3");
    // R2: address 3 changes nothing
    wr(2'd3, 12'hFFF, 12'h123, "R2");
    for (int i = 0; i < 4; i++) tick(12'h123, "R2");
    wr(2'd0, 12'h000, 12'h000, "R2");
    wr(2'd1, 12'hFFF, 12'h000, "R2");
    for (int i = 0; i < 3; i++) tick(12'h000, "R6");
    // R5, R6: single-cycle pulse per channel, with monitor following it (R8)
    for (int c = 0; c < NUM_CH; c++) begin
      wr(2'd2, NUM_CH'(c), 12'h000, "R8");
      tick(NUM_CH'(1) << c, "R5");
      for (int k = 0; k < 4; k++) tick(12'h000, "R6");
    end
    // R7: multi-cycle pulses per channel
    for (int c = 0; c < NUM_CH; c++) begin
      for (int k = 0; k < 3; k++) tick(NUM_CH'(1) << c, "R7");
      for (int k = 0; k < 4; k++) tick(12'h000, "R7");
    end
    // R10: mixed masks, random activity on all channels
    wr(2'd1, 12'h0F3, 12'h000, "R10");
    wr(2'd0, 12'h30C, 12'h000, "R10");
    for (int i = 0; i < 60; i++) tick(next_pat(), "R10");
    // R8 and R9: sweep monitor selector over every code
    for (int s = 0; s < (1 << SEL_W); s++) begin
      wr(2'd2, NUM_CH'(s), next_pat(), (s < NUM_CH) ? "R8" : "R9");
      for (int k = 0; k < 6; k++) tick(next_pat(), (s < NUM_CH) ? "R8" : "R9");
    end
    // R6: enable with stretch after inverted short pulses
    wr(2'd1, 12'hFFF, 12'h000, "R6");
    wr(2'd0, 12'hFFF, 12'hFFF, "R6");
    for (int i = 0; i < 30; i++) tick(~(next_pat() & next_pat()), "R6");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule